// File: doc/BRIEF.md
# Multiplexed Parallel Pin Controller

This block manages a bank of up to 32 bidirectional pins. Each implemented pin is owned either by the controller, which acts as a general-purpose I/O, or by a peripheral function that shares the pin. Some pins can be built as dedicated general-purpose pins, and these never pass to a peripheral. Every configuration bit is changed only through a pair of write-one strobes. One register of the pair sets the written bits and the other clears them. A matching status register reads the current value.

The block drives an output enable and an output data bit for each pad. It synchronises the incoming pad level and can pass it through a per-pin glitch filter. The result goes to the peripheral and to a pad-level status register. Open-drain operation is selected per pin and applies under either owner.

Top module: `pin_mux_ctrl`

## Requirements
- R1: Bits of pins outside `IMPL_MASK` ignore every write and read as zero in every register.
- R2: A write of ones to OWN_SET hands those pins to the controller, and a write of ones to OWN_CLR hands them to the peripheral. OWN_STAT reads 1 for controller-owned pins and 0 for peripheral-owned pins. Zero bits in the written data leave the state unchanged.
- R3: For pins in `GPIO_MASK`, writes to OWN_SET and OWN_CLR are ignored, and OWN_STAT always reads 1.
- R4: After reset every implemented pin is owned by the controller. Direction, level, filter and open-drain bits are all 0, so no pad is driven.
- R5: `per_in` is 0 for controller-owned pins. For peripheral-owned pins it carries the conditioned pad level of R8/R10.
- R6: DIR_SET and DIR_CLR set and clear the direction bits, and DIR_STAT reads them back. The direction drives `pad_oe` only while the controller owns the pin. While the peripheral owns the pin, `per_oe` drives `pad_oe`.
- R7: LVL_SET and LVL_CLR set and clear the output level bits, and LVL_STAT reads them back. The level appears on `pad_out` while the controller owns the pin. While the peripheral owns the pin, `per_out` appears on `pad_out`.
- R8: PAD_STAT returns the pad level through a two-flop synchronizer, whatever the owner or direction. An unfiltered change shows two clock edges after it is sampled.
- R9: ODN_SET and ODN_CLR set and clear open-drain mode, and ODN_STAT reads it back. In open-drain mode `pad_oe` is asserted only when the selected output data is 0, under either owner.
- R10: FLT_SET and FLT_CLR set and clear the filter enable, and FLT_STAT reads it back. When the filter is enabled, a synchronised level passes only after it has been equal on two consecutive samples. A pad pulse of one clock period is therefore never passed. The filter affects both `per_in` and PAD_STAT.
- R11: Word addresses on `bus_addr`: OWN_SET 0, OWN_CLR 1, OWN_STAT 2, DIR_SET 3, DIR_CLR 4, DIR_STAT 5, LVL_SET 6, LVL_CLR 7, LVL_STAT 8, FLT_SET 9, FLT_CLR 10, FLT_STAT 11, ODN_SET 12, ODN_CLR 13, ODN_STAT 14, PAD_STAT 15. A write happens on a rising edge with `bus_wen` high. `bus_rdata` reflects the addressed register combinationally. Set and clear addresses read 0. Bit i of each register belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | PIN_W | Write data, one bit per pin |
| bus_rdata | output | PIN_W | Read data of the addressed register |
| pad_in | input | PIN_W | Level seen at each pad |
| pad_oe | output | PIN_W | Pad output enable |
| pad_out | output | PIN_W | Pad output data |
| per_oe | input | PIN_W | Peripheral output enable request |
| per_out | input | PIN_W | Peripheral output data |
| per_in | output | PIN_W | Conditioned pad level toward the peripheral |

## Verification
The assertions assume a single write strobe per cycle. With one write strobe, a set and a clear of the same register never coincide, so the set-takes-effect property needs no extra guard. They also take `pad_in` as asynchronous but stable between edges long enough to be sampled. The stimulus drives every input a fixed delay after the falling clock edge and changes pads only in whole clock periods. This produces single-period glitches, two-period pulses and longer levels. After reset, writes and pad activity start only once the internal reset release has passed.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [3:0] {
    A_OWN_SET  = 4'd0,
    A_OWN_CLR  = 4'd1,
    A_OWN_STAT = 4'd2,
    A_DIR_SET  = 4'd3,
    A_DIR_CLR  = 4'd4,
    A_DIR_STAT = 4'd5,
    A_LVL_SET  = 4'd6,
    A_LVL_CLR  = 4'd7,
    A_LVL_STAT = 4'd8,
    A_FLT_SET  = 4'd9,
    A_FLT_CLR  = 4'd10,
    A_FLT_STAT = 4'd11,
    A_ODN_SET  = 4'd12,
    A_ODN_CLR  = 4'd13,
    A_ODN_STAT = 4'd14,
    A_PAD_STAT = 4'd15
  } pio_addr_e;
endpackage

// File: rtl/pio_cfg_bank.sv
module pio_cfg_bank #(
  parameter int          W     = 32,
  parameter logic [W-1:0] IMPL  = '1,
  parameter logic [W-1:0] FIXED = '0,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] WRITABLE = IMPL & ~FIXED;
  localparam logic [W-1:0] CONST_V  = IMPL & FIXED;

  logic [W-1:0] q_nx;

  // clear is applied after set, so clear wins on a coincident strobe
  always_comb begin
    q_nx = q;
    if (set_en) q_nx = q_nx | (wdata & WRITABLE);
    if (clr_en) q_nx = q_nx & ~(wdata & WRITABLE);
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (WRITABLE[i]) begin : g_ff
      logic bit_q;
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)              bit_q <= RST[i];
        else if (set_en | clr_en) bit_q <= q_nx[i];
      end
      assign q[i] = bit_q;
    end else begin : g_const
      assign q[i] = CONST_V[i];
    end
  end

  p_clr_applies_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en |=> ((q & $past(wdata & WRITABLE)) == '0));

  p_set_applies_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_en && !clr_en) |=> ((q & $past(wdata & WRITABLE)) == $past(wdata & WRITABLE)));

  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_en || clr_en) |=> ((q & ~WRITABLE) == $past(q & ~WRITABLE)));
endmodule

// File: rtl/pio_in_filter.sv
module pio_in_filter #(
  parameter int          W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] flt_en,
  output logic [W-1:0] lvl
);
  logic [W-1:0] sync1_q, sync2_q, prev_q, filt_q;
  logic [W-1:0] stable, filt_nx;

  always_comb begin
    stable  = ~(sync2_q ^ prev_q);
    filt_nx = (filt_q & ~stable) | (sync2_q & stable);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      filt_q  <= '0;
    end else begin
      sync1_q <= pad_in & IMPL;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      filt_q  <= filt_nx;
    end
  end

  assign lvl = ((flt_en & filt_q) | (~flt_en & sync2_q)) & IMPL;

  p_filter_needs_two_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    ((filt_q ^ $past(filt_q)) & ($past(sync2_q) ^ $past(prev_q))) == '0);
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
  parameter int          W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] odn,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] in_lvl,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] per_in
);
  logic [W-1:0] sel_data, sel_drive;

  always_comb begin
    sel_data  = (own & lvl) | (~own & per_out);
    sel_drive = (own & dir) | (~own & per_oe);
    pad_out   = sel_data & IMPL;
    pad_oe    = sel_drive & ~(odn & sel_data) & IMPL;
    per_in    = in_lvl & ~own & IMPL;
  end

  always_comb begin
    a_odn_no_high_r9: assert ((pad_oe & odn & pad_out) == '0);
    a_per_in_masked_r5: assert ((per_in & own) == '0);
  end
endmodule

// File: rtl/pin_mux_ctrl.sv
module pin_mux_ctrl #(
  parameter int              PIN_W     = 32,
  parameter logic [PIN_W-1:0] IMPL_MASK = 32'h0FFF_FFFF,
  parameter logic [PIN_W-1:0] GPIO_MASK = 32'h0000_00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wen,
  input  logic [3:0]       bus_addr,
  input  logic [PIN_W-1:0] bus_wdata,
  output logic [PIN_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0] pad_in,
  output logic [PIN_W-1:0] pad_oe,
  output logic [PIN_W-1:0] pad_out,
  input  logic [PIN_W-1:0] per_oe,
  input  logic [PIN_W-1:0] per_out,
  output logic [PIN_W-1:0] per_in
);
  import pio_pkg::*;

  localparam int NBANK = 5;
  localparam logic [PIN_W-1:0] GPIO_IMPL = GPIO_MASK & IMPL_MASK;

  // reset: asserted asynchronously, released after two edges
  logic rst_s1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ni   <= rst_s1_q;
    end
  end

  pio_addr_e addr;
  assign addr = pio_addr_e'(bus_addr);

  // bank index: 0 own, 1 dir, 2 lvl, 3 flt, 4 odn; set at 3k, clear at 3k+1
  logic [NBANK-1:0]       set_en, clr_en;
  logic [PIN_W-1:0]       bank_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb begin
      set_en[b] = bus_wen && (bus_addr == 4'(3 * b));
      clr_en[b] = bus_wen && (bus_addr == 4'(3 * b + 1));
    end
    pio_cfg_bank #(
      .W     (PIN_W),
      .IMPL  (IMPL_MASK),
      .FIXED ((b == 0) ? GPIO_IMPL : '0),
      .RST   ((b == 0) ? IMPL_MASK : '0)
    ) u_bank (
      .clk    (clk),
      .rst_ni (rst_ni),
      .set_en (set_en[b]),
      .clr_en (clr_en[b]),
      .wdata  (bus_wdata),
      .q      (bank_q[b])
    );
  end

  logic [PIN_W-1:0] in_lvl;

  pio_in_filter #(.W(PIN_W), .IMPL(IMPL_MASK)) u_filter (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pad_in (pad_in),
    .flt_en (bank_q[3]),
    .lvl    (in_lvl)
  );

  pio_pad_mux #(.W(PIN_W), .IMPL(IMPL_MASK)) u_mux (
    .own     (bank_q[0]),
    .dir     (bank_q[1]),
    .lvl     (bank_q[2]),
    .odn     (bank_q[4]),
    .per_oe  (per_oe),
    .per_out (per_out),
    .in_lvl  (in_lvl),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .per_in  (per_in)
  );

  always_comb begin
    case (addr)
      A_OWN_STAT: bus_rdata = bank_q[0];
      A_DIR_STAT: bus_rdata = bank_q[1];
      A_LVL_STAT: bus_rdata = bank_q[2];
      A_FLT_STAT: bus_rdata = bank_q[3];
      A_ODN_STAT: bus_rdata = bank_q[4];
      A_PAD_STAT: bus_rdata = in_lvl;
      default:    bus_rdata = '0;
    endcase
  end

  p_rdata_unimpl_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rdata & ~IMPL_MASK) == '0);

  p_gpio_owned_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (bank_q[0] & GPIO_IMPL) == GPIO_IMPL);

  p_reset_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ni) |-> (bank_q[1] == '0 && bank_q[4] == '0));
endmodule

// File: tb/pin_mux_ctrl_bench.sv
module pin_mux_ctrl_bench;
  localparam logic [31:0] IMPL = 32'h0FFF_FFFF;
  localparam logic [31:0] GPIO = 32'h0000_00FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pad_in, pad_oe, pad_out, per_oe, per_out, per_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 1'b0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pin_mux_ctrl u_pin_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .per_oe(per_oe),
    .per_out(per_out), .per_in(per_in)
  );

  // behavioural reference model
  logic [31:0] m_own, m_dir, m_lvl, m_flt, m_odn, m_filt;
  logic [31:0] pq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = IMPL; m_dir = '0; m_lvl = '0; m_flt = '0; m_odn = '0; m_filt = '0;
      pq = {32'h0, 32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] w, eq;
      pq.push_front(pad_in & IMPL);
      void'(pq.pop_back());
      eq = ~(pq[2] ^ pq[3]);
      m_filt = (m_filt & ~eq) | (pq[2] & eq);
      w = bus_wdata & IMPL;
      if (bus_wen) begin
        case (bus_addr)
          4'd0:  m_own = m_own | (w & ~GPIO);
          4'd1:  m_own = m_own & ~(w & ~GPIO);
          4'd3:  m_dir = m_dir | w;
          4'd4:  m_dir = m_dir & ~w;
          4'd6:  m_lvl = m_lvl | w;
          4'd7:  m_lvl = m_lvl & ~w;
          4'd9:  m_flt = m_flt | w;
          4'd10: m_flt = m_flt & ~w;
          4'd12: m_odn = m_odn | w;
          4'd13: m_odn = m_odn & ~w;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_in();
    return ((m_flt & m_filt) | (~m_flt & pq[1])) & IMPL;
  endfunction

  function automatic logic [31:0] m_data();
    return ((m_own & m_lvl) | (~m_own & per_out)) & IMPL;
  endfunction

  function automatic logic [31:0] m_oe();
    logic [31:0] drv;
    drv = (m_own & m_dir) | (~m_own & per_oe);
    return drv & ~(m_odn & m_data()) & IMPL;
  endfunction

  function automatic logic [31:0] m_rd(input logic [3:0] a);
    case (a)
      4'd2:  return m_own;
      4'd5:  return m_dir;
      4'd8:  return m_lvl;
      4'd11: return m_flt;
      4'd14: return m_odn;
      4'd15: return m_in();
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'd2:  return "R2 R11";
      4'd5:  return "R6 R11";
      4'd8:  return "R7 R11";
      4'd11: return "R10 R11";
      4'd14: return "R9 R11";
      4'd15: return "R8 R11";
      default: return "R1 R11";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      chk(bus_rdata, m_rd(bus_addr), rd_tag(bus_addr));
      chk(pad_oe,  m_oe(),   "R6 R9 pad_oe");
      chk(pad_out, m_data(), "R7 pad_out");
      chk(per_in,  m_in() & ~m_own, "R5 per_in");
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wen = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(bus_rdata, exp, tag);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit seen;
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; per_oe = '0; per_out = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk_on = 1'b1;

    // R4: reset state
    rd_chk(4'd2, IMPL, "R4 own after reset");
    rd_chk(4'd5, '0, "R4 dir after reset");
    rd_chk(4'd8, '0, "R4 lvl after reset");
    rd_chk(4'd11, '0, "R4 flt after reset");
    rd_chk(4'd14, '0, "R4 odn after reset");
    chk(pad_oe, '0, "R4 pad_oe after reset");

    // R1: all-ones writes only land on implemented pins
    wr(4'd3, '1); wr(4'd6, '1); wr(4'd9, '1); wr(4'd12, '1);
    rd_chk(4'd5, IMPL, "R1 dir unimplemented bits");
    rd_chk(4'd8, IMPL, "R1 lvl unimplemented bits");
    rd_chk(4'd11, IMPL, "R1 flt unimplemented bits");
    rd_chk(4'd14, IMPL, "R1 odn unimplemented bits");
    wr(4'd4, '1); wr(4'd7, '1); wr(4'd10, '1); wr(4'd13, '1);

    // R3: dedicated pins stay with the controller
    wr(4'd1, '1);
    rd_chk(4'd2, GPIO, "R3 own after clear-all");
    wr(4'd0, 32'h00F0_0000);
    rd_chk(4'd2, GPIO | 32'h00F0_0000, "R2 own set");
    wr(4'd1, 32'h0030_0000);
    rd_chk(4'd2, GPIO | 32'h00C0_0000, "R2 own clear");

    // R9: open drain on controller pin 3
    wr(4'd12, 32'h8); wr(4'd3, 32'h8); wr(4'd6, 32'h8);
    tick();
    chk({31'd0, pad_oe[3]}, 32'd0, "R9 high releases pad");
    wr(4'd7, 32'h8);
    tick();
    chk({31'd0, pad_oe[3]}, 32'd1, "R9 low drives pad");

    // R6: direction ignored on peripheral-owned pin 21
    wr(4'd3, 32'h0020_0000);
    per_oe = '0;
    tick();
    chk({31'd0, pad_oe[21]}, 32'd0, "R6 dir ignored for peripheral");

    // R10: single-period glitch on filtered peripheral pin 20 is rejected
    wr(4'd9, 32'h0010_0000);
    repeat (6) tick();
    pad_in[20] = 1'b1; tick(); pad_in[20] = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin tick(); seen |= per_in[20]; end
    chk({31'd0, seen}, 32'd0, "R10 glitch rejected");
    pad_in[20] = 1'b1; tick(); tick(); pad_in[20] = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin tick(); seen |= per_in[20]; end
    chk({31'd1, seen} & 32'd1, 32'd1, "R10 two-period pulse passes");

    // mixed random traffic checked against the model every clock
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      per_oe  = $urandom;
      per_out = $urandom;
      if (r[3:0] == 4'd0) pad_in = $urandom;
      else pad_in = pad_in ^ ($urandom & $urandom & $urandom);
      if (r[5:4] == 2'd0) begin
        bus_wen = 1'b1;
        bus_addr = 4'(r[11:8] % 15);
        bus_wdata = $urandom;
      end else begin
        bus_wen = 1'b0;
        bus_addr = r[15:12];
      end
      tick();
    end
    bus_wen = 1'b0;
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule